// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns a serial input line into 8-bit or 9-bit characters. The line idles high. A falling edge starts a frame, and the frame is timed by a sample tick that runs at sixteen times the bit rate. The tick comes from outside the block. Each data bit is sampled at the middle of its bit period and shifted into a shift register, least significant bit first. When the stop bit has been sampled, the finished character moves into a single-entry receive data register.

Software reads the character through a one-cycle read strobe and watches four status outputs:
- a receive-complete flag,
- a framing-error flag,
- an overrun flag,
- the ninth data bit when 9-bit characters are selected.

An interrupt request follows the receive-complete flag while its enable is set. A receiver enable input gates whether new characters can set any flag.

The overrun flag is deliberately delayed. When a character finishes while the previous one is still unread, the new character is dropped and the overrun is remembered internally. The flag becomes visible only when software reads the older character. The next transferred character clears it.

Top module: `serialRxFlags`

## Requirements
- R1: With the line idle high, a falling edge starts a frame. Each data bit is sampled once at the middle of its 16-tick period, least significant bit first. The received byte appears on `rxData` and `rxDone` goes to 1.
- R2: The start bit is sampled again 8 ticks after the falling edge. If the line is high at that point, the event is ignored: no flag changes, and a later valid frame is received normally.
- R3: When `nineBitMode` is 1, nine data bits are received and the ninth appears on `rxNinth`. When `nineBitMode` is 0, eight data bits are received and `rxNinth` reads 0.
- R4: `rxDone` is set when a character is transferred into the data register. A pulse on `dataRead` clears it. A read pulse while `rxDone` is 0 changes nothing.
- R5: `frameErr` is set to 1 when the stop bit of a transferred character samples as 0. It returns to 0 when a later transferred character has a stop bit of 1.
- R6: If a character completes while `rxDone` is 1, that newest character is lost and `rxData` keeps the older character. `overrunFlag` stays 0 until the older character is read, then reads 1. The next transferred character clears it.
- R7: While `rxEnable` is 0, incoming frames are ignored and no flag can become set. Clearing `rxEnable` leaves flags that are already set unchanged.
- R8: `rxIrq` is 1 exactly when `rxDone` is 1 and `rxIntEnable` is 1.
- R9: If a read pulse and the completion of a character fall in the same cycle, the read is served first. The new character is then transferred, `rxDone` stays 1, and no overrun is recorded.
- R10: After reset, `rxDone`, `frameErr`, `overrunFlag`, `rxNinth` and `rxIrq` are 0, and `rxData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxLine | input | 1 | Serial input line, idle high |
| rxEnable | input | 1 | Receiver enable |
| nineBitMode | input | 1 | 1 selects 9-bit characters |
| rxIntEnable | input | 1 | Receive-complete interrupt enable |
| dataRead | input | 1 | One-cycle strobe that consumes the data register |
| rxData | output | 8 | Received data byte |
| rxNinth | output | 1 | Ninth received bit |
| rxDone | output | 1 | Receive-complete flag |
| frameErr | output | 1 | Framing-error flag |
| overrunFlag | output | 1 | Overrun flag, visible after the older character is read |
| rxIrq | output | 1 | Receive-complete interrupt request |

## Verification
The read strobe and the completion of a new character can land in the same clock cycle. In that cycle one character is consumed and another is stored, so the two actions compete for the single register. The bench keeps an unread character waiting, then sends a second frame while sliding a single read pulse across every cycle around the middle of its stop bit. After each run, exactly one of two outcomes must hold:
- the new character is held with `rxDone` at 1 and no overrun, or
- the register is empty with `overrunFlag` at 1.

Both outcomes must appear across the sweep, and the boundary cycle must count as a clean transfer.

// File: rtl/serialRxPkg.sv
package serialRxPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic charDone;
  } rxStrobe_t;

endpackage

// File: rtl/serialRxCtrl.sv
module serialRxCtrl
  import serialRxPkg::*;
#(
  parameter int TICKS  = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineIn,
  input  logic      rxEnable,
  input  logic      nineBitMode,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(TICKS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(TICKS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastBitIdx;
  logic             lastLine;
  logic             fallSeen;

  assign lastBitIdx = nineBitMode ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
  assign fallSeen   = lastLine && !lineIn;

  // line value seen at the previous tick, for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lastLine <= 1'b1;
    else if (sampleTick) lastLine <= lineIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (sampleTick) begin
      unique case (state)
        ST_IDLE: begin
          if (fallSeen) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tickCnt == MID_CNT) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= lineIn ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == lastBitIdx) state <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.shiftEn  = rxEnable && sampleTick && (state == ST_DATA) && (tickCnt == LAST_CNT);
    strobe.charDone = rxEnable && sampleTick && (state == ST_STOP) && (tickCnt == LAST_CNT);
  end

  // R2: data phase is entered only when the mid-start sample read low
  a_r2_start_confirmed: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && $past(state) == ST_START) |-> $past(!lineIn));

endmodule

// File: rtl/serialRxPath.sv
module serialRxPath
  import serialRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              rxEnable,
  input  logic              nineBitMode,
  input  logic              dataRead,
  input  rxStrobe_t         strobe,
  output logic              lineSync,
  output logic [DATA_W-1:0] dataReg,
  output logic              ninthReg,
  output logic              rxDone,
  output logic              frameErr,
  output logic              overrunFlag
);

  logic [1:0]      syncPipe;
  logic [DATA_W:0] shiftReg;
  logic            ovrPending;
  logic            readHit;
  logic            roomFree;

  assign lineSync = syncPipe[1];
  assign readHit  = dataRead && rxDone;
  assign roomFree = !rxDone || readHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= 2'b11;
    else       syncPipe <= {syncPipe[0], rxLine};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      if (nineBitMode) shiftReg <= {lineSync, shiftReg[DATA_W:1]};
      else             shiftReg <= {1'b0, lineSync, shiftReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg     <= '0;
      ninthReg    <= 1'b0;
      rxDone      <= 1'b0;
      frameErr    <= 1'b0;
      overrunFlag <= 1'b0;
      ovrPending  <= 1'b0;
    end else if (strobe.charDone && roomFree) begin
      dataReg     <= shiftReg[DATA_W-1:0];
      ninthReg    <= nineBitMode & shiftReg[DATA_W];
      frameErr    <= ~lineSync;
      rxDone      <= 1'b1;
      overrunFlag <= 1'b0;
      ovrPending  <= 1'b0;
    end else begin
      if (readHit) begin
        rxDone      <= 1'b0;
        overrunFlag <= ovrPending;
        ovrPending  <= 1'b0;
      end
      if (strobe.charDone) ovrPending <= 1'b1;
    end
  end

  a_r4_clear_by_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxDone) |-> $past(dataRead));

  a_r6_ovr_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $past(dataRead && rxDone));

  a_r6_data_kept: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !dataRead) |=> $stable(dataReg));

  a_r7_no_set_off: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !rxDone) |=> !rxDone);

  a_r7_fe_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> $stable(frameErr));

  a_r9_read_first: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.charDone && rxDone && dataRead) |=> (rxDone && !overrunFlag));

endmodule

// File: rtl/serialRxFlags.sv
module serialRxFlags
  import serialRxPkg::*;
#(
  parameter int TICKS  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic              rxEnable,
  input  logic              nineBitMode,
  input  logic              rxIntEnable,
  input  logic              dataRead,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxDone,
  output logic              frameErr,
  output logic              overrunFlag,
  output logic              rxIrq
);

  rxStrobe_t strobe;
  logic      lineSync;

  serialRxCtrl #(.TICKS(TICKS), .DATA_W(DATA_W)) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleTick  (sampleTick),
    .lineIn      (lineSync),
    .rxEnable    (rxEnable),
    .nineBitMode (nineBitMode),
    .strobe      (strobe)
  );

  serialRxPath #(.DATA_W(DATA_W)) path (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .rxEnable    (rxEnable),
    .nineBitMode (nineBitMode),
    .dataRead    (dataRead),
    .strobe      (strobe),
    .lineSync    (lineSync),
    .dataReg     (rxData),
    .ninthReg    (rxNinth),
    .rxDone      (rxDone),
    .frameErr    (frameErr),
    .overrunFlag (overrunFlag)
  );

  assign rxIrq = rxDone & rxIntEnable;

endmodule

// File: tb/serialRxFlags_test.sv
module serialRxFlags_test;

  localparam int BIT_CLKS = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       rxEnable = 1'b1;
  logic       nineBitMode = 1'b0;
  logic       rxIntEnable = 1'b1;
  logic       dataRead = 1'b0;
  logic [7:0] rxData;
  logic       rxNinth, rxDone, frameErr, overrunFlag, rxIrq;
  logic [1:0] tickDiv = 2'd0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tickDiv    <= tickDiv + 2'd1;
    sampleTick <= (tickDiv == 2'd3);
  end

  serialRxFlags uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .nineBitMode(nineBitMode), .rxIntEnable(rxIntEnable),
    .dataRead(dataRead), .rxData(rxData), .rxNinth(rxNinth), .rxDone(rxDone),
    .frameErr(frameErr), .overrunFlag(overrunFlag), .rxIrq(rxIrq)
  );

  // {nine, stop, data[8:0]}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 1'b1, 9'h055},
    {1'b0, 1'b1, 9'h0A3},
    {1'b0, 1'b0, 9'h00F},
    {1'b0, 1'b1, 9'h0F0},
    {1'b1, 1'b1, 9'h1C5},
    {1'b1, 1'b1, 9'h03A},
    {1'b1, 1'b0, 9'h100},
    {1'b0, 1'b1, 9'h0FF}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] d, input bit nine, input bit stopV);
    rxLine = 1'b0;
    waitClks(BIT_CLKS);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxLine = d[i];
      waitClks(BIT_CLKS);
    end
    rxLine = stopV;
    waitClks(BIT_CLKS);
    rxLine = 1'b1;
    waitClks(BIT_CLKS);
  endtask

  task automatic readData();
    @(negedge clk) dataRead = 1'b1;
    @(negedge clk) dataRead = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int sawLoad = 0;
    int sawLost = 0;
    waitClks(5);
    rstN = 1'b1;
    waitClks(5);

    // R10 reset state
    check(rxDone == 0 && frameErr == 0 && overrunFlag == 0, "R10", "flags",
          {rxDone, frameErr, overrunFlag}, 0);
    check(rxData == 8'h00 && rxNinth == 0 && rxIrq == 0, "R10", "data/irq",
          {rxData, rxNinth, rxIrq}, 0);

    // R4 read while empty
    readData();
    waitClks(2);
    check(rxDone == 0 && overrunFlag == 0, "R4", "empty read", {rxDone, overrunFlag}, 0);

    // R1 R3 R5 R8 vector table
    foreach (VEC[k]) begin
      logic       nine;
      logic       stopV;
      logic [8:0] d;
      nine  = VEC[k][10];
      stopV = VEC[k][9];
      d     = VEC[k][8:0];
      nineBitMode = nine;
      sendFrame(d, nine, stopV);
      check(rxDone == 1, "R1", "rxDone", rxDone, 1);
      check(rxData == d[7:0], "R1", "rxData", rxData, d[7:0]);
      check(rxNinth == (nine & d[8]), "R3", "rxNinth", rxNinth, nine & d[8]);
      check(frameErr == !stopV, "R5", "frameErr", frameErr, !stopV);
      check(rxIrq == 1, "R8", "irq high", rxIrq, 1);
      readData();
      waitClks(2);
      check(rxDone == 0 && rxIrq == 0, "R4", "cleared by read", {rxDone, rxIrq}, 0);
    end
    nineBitMode = 1'b0;

    // R2 false start
    rxLine = 1'b0;
    waitClks(16);
    rxLine = 1'b1;
    waitClks(200);
    check(rxDone == 0 && frameErr == 0, "R2", "glitch ignored", {rxDone, frameErr}, 0);
    sendFrame(9'h03C, 1'b0, 1'b1);
    check(rxDone == 1 && rxData == 8'h3C, "R2", "after glitch", rxData, 8'h3C);
    readData();

    // R8 interrupt disabled
    rxIntEnable = 1'b0;
    sendFrame(9'h081, 1'b0, 1'b1);
    check(rxDone == 1 && rxIrq == 0, "R8", "irq masked", rxIrq, 0);
    readData();
    rxIntEnable = 1'b1;

    // R6 overrun sequence
    sendFrame(9'h011, 1'b0, 1'b1);
    sendFrame(9'h022, 1'b0, 1'b1);
    check(rxDone == 1 && rxData == 8'h11, "R6", "older kept", rxData, 8'h11);
    check(overrunFlag == 0, "R6", "ovr hidden", overrunFlag, 0);
    readData();
    waitClks(2);
    check(overrunFlag == 1 && rxDone == 0, "R6", "ovr visible", {overrunFlag, rxDone}, 2'b10);
    sendFrame(9'h033, 1'b0, 1'b1);
    check(overrunFlag == 0 && rxData == 8'h33, "R6", "ovr cleared", {overrunFlag, rxData}, 8'h33);
    readData();

    // R7 enable handling
    sendFrame(9'h0AA, 1'b0, 1'b0);
    check(frameErr == 1 && rxDone == 1, "R5", "fe set", {frameErr, rxDone}, 2'b11);
    rxEnable = 1'b0;
    waitClks(10);
    check(frameErr == 1 && rxDone == 1, "R7", "flags kept", {frameErr, rxDone}, 2'b11);
    readData();
    sendFrame(9'h055, 1'b0, 1'b1);
    check(rxDone == 0 && frameErr == 1, "R7", "frame ignored", {rxDone, frameErr}, 2'b01);
    rxEnable = 1'b1;
    waitClks(20);
    sendFrame(9'h066, 1'b0, 1'b1);
    check(frameErr == 0 && rxData == 8'h66, "R5", "fe cleared", {frameErr, rxData}, 8'h66);
    readData();

    // R9 read pulse swept across completion
    for (int off = 596; off <= 628; off++) begin
      readData();
      sendFrame(9'h05A, 1'b0, 1'b1);
      fork
        sendFrame(9'h0B6, 1'b0, 1'b1);
        begin
          waitClks(off);
          dataRead = 1'b1;
          waitClks(1);
          dataRead = 1'b0;
        end
      join
      if (rxDone) begin
        sawLoad++;
        check(rxData == 8'hB6 && overrunFlag == 0, "R9", "load path",
              {overrunFlag, rxData}, 8'hB6);
      end else begin
        sawLost++;
        check(overrunFlag == 1, "R6", "lost path", overrunFlag, 1);
      end
    end
    check(sawLoad > 0, "R9", "load seen", sawLoad, 1);
    check(sawLost > 0, "R6", "lost seen", sawLost, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule